// File: doc/BRIEF.md
# Serial Three-Wire Configuration Register Port

This block is a write-only configuration port. A host sends a frame on a serial clock, a serial data line and a load strobe. The block oversamples these lines in the system clock domain and assembles an address and a data word from each frame. It places each accepted write in a shadow copy of a small register file. The values that downstream logic sees are held in a separate active copy. A register moves from shadow to active only on a commit event.

The commit event is chosen per register. Load-synchronous registers commit when the load strobe rises. Frame-synchronous registers commit on the first line-sync (HD) falling edge that comes after a frame-sync (VD) falling edge. Some values span two neighbouring addresses. The host writes the lower half first and the upper half second, and both halves become active in the same cycle. One register acts as an update lock: while its bit 0 is set, no other register can commit. Pending writes are kept until the lock is released.

The active file is presented as one flat vector. Register i occupies bits [i*DW +: DW].

Top module: `cfg3w_port`

## Requirements
- R1: After synchronous reset, register i of the active file reads (i*7+3) mod 64, except the lock register at address 25, which reads 0. No write is pending, so a later commit event changes nothing.
- R2: Serial data is sampled on rising serial-clock edges while the load strobe is low. The first 8 bits form the address and the next 6 form the data, both least significant bit first.
- R3: A frame of 14, 15 or 16 bits is accepted, and the bits after the 14th are ignored. A frame of more than 16 bits is discarded.
- R4: A frame of fewer than 14 bits is discarded. While the load strobe is high the bit count stays at zero, so serial-clock edges in that time do not shift a later frame.
- R5: A write to a load-synchronous register becomes active at the load-strobe rise that ends its frame. The active value changes at the third system-clock rising edge at which the strobe is sampled high.
- R6: A write to a frame-synchronous register (addresses 8 to 15, plus the pair 10/11) stays pending until an HD falling edge that follows a VD falling edge. HD falls without a prior VD fall do not commit it.
- R7: The address pairs 4/5 and 10/11 are wide registers. A write to the lower address alone never commits. A write to the upper address commits both halves in the same cycle.
- R8: The lower half of a wide pair uses the commit mode of its upper address. Address 4 is flagged frame-synchronous but follows address 5 and commits on the load strobe.
- R9: While bit 0 of address 25 is 1, no other register commits and their writes stay pending. Address 25 always commits on the load strobe, even while it is set. Writes held back by the lock commit at the first suitable event after the lock is cleared.
- R10: A write to an address of 32 or above changes no register.
- R11: VD and HD pass through two synchronizing flops. A frame-synchronous commit appears at the third system-clock rising edge at which HD is sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock from the host |
| ser_dat | input | 1 | Serial data, least significant bit first |
| ser_load | input | 1 | Load strobe; low during a frame, its rise ends the frame |
| vsync_in | input | 1 | Frame sync; its falling edge arms a frame-synchronous commit |
| hsync_in | input | 1 | Line sync; its falling edge performs an armed commit |
| cfg_q | output | NUM_REGS*DW | Active register file, register i at bits [i*DW +: DW] |

## Verification
The bench sends frames of 12, 14, 16 and 17 bits. This shows whether the bit-count window accepts only 14 to 16 bits and whether the data field is taken from the right positions. Serial-clock edges sent while the strobe is high, followed by a normal frame, show whether the counter is really held while the strobe is high. Separate HD-only and VD-then-HD pulse patterns distinguish an armed commit from a bare line edge. A lower-half-only write and a lower-then-upper write separate atomic wide commits from per-address commits. Lock-set, lock-clear and follow-up strobe sequences show that held writes survive and commit only once the lock is clear.

// File: rtl/cfg3w_pkg.sv
package cfg3w_pkg;

  // Reset value of one configuration register (the lock register resets to 0)
  function automatic logic [7:0] def_val(input int idx, input int lock_idx);
    if (idx == lock_idx) return 8'd0;
    return 8'((idx * 7 + 3) % 64);
  endfunction

endpackage

// File: rtl/cfg3w_sync.sv
module cfg3w_sync #(
  parameter int W  = 5,
  parameter int EW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  raw,
  output logic [W-1:0]  lvl,
  output logic [EW-1:0] prv
);
  logic [W-1:0]  s1, s2;
  logic [EW-1:0] s3;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= '0;
      s2 <= '0;
      s3 <= '0;
    end else begin
      s1 <= raw;
      s2 <= s1;
      s3 <= s2[EW-1:0];
    end
  end

  assign lvl = s2;
  assign prv = s3;
endmodule

// File: rtl/cfg3w_frame_rx.sv
module cfg3w_frame_rx #(
  parameter int AW    = 8,
  parameter int DW    = 6,
  parameter int EXTRA = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_strobe,
  input  logic          bit_val,
  input  logic          load_lvl,
  input  logic          load_rise,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  localparam int NB   = AW + DW;
  localparam int MAXB = NB + EXTRA;
  localparam int CW   = $clog2(MAXB + 2);

  logic [CW-1:0] cnt;
  logic [NB-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      sh  <= '0;
    end else if (load_lvl) begin
      cnt <= '0;
    end else if (bit_strobe) begin
      if (cnt < CW'(NB)) sh <= {bit_val, sh[NB-1:1]};
      if (cnt <= CW'(MAXB)) cnt <= cnt + 1'b1;
    end
  end

  assign wr_en   = load_rise && (cnt >= CW'(NB)) && (cnt <= CW'(MAXB));
  assign wr_addr = sh[AW-1:0];
  assign wr_data = sh[NB-1:AW];
endmodule

// File: rtl/cfg3w_bank.sv
module cfg3w_bank
  import cfg3w_pkg::*;
#(
  parameter int                N     = 32,
  parameter int                AW    = 8,
  parameter int                DW    = 6,
  parameter int                LOCK  = 25,
  parameter logic [N-1:0]      VS    = '0,
  parameter logic [N-1:0]      WLO   = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic            load_evt,
  input  logic            frame_evt,
  output logic [N*DW-1:0] cfg_q,
  output logic [N-1:0]    pend_q
);
  logic lock_on;
  assign lock_on = cfg_q[LOCK*DW];

  for (genvar i = 0; i < N; i++) begin : g_reg
    localparam bit IS_LO   = WLO[i] && (i < N-1);
    localparam bit IS_LOCK = (i == LOCK);
    localparam bit MODE_V  = IS_LOCK ? 1'b0 : (IS_LO ? VS[(i < N-1) ? i+1 : i] : VS[i]);
    localparam logic [DW-1:0] RV = DW'(def_val(i, LOCK));

    logic [DW-1:0] shd_r, act_r, shd_nx;
    logic          pnd_r, pnd_nx, hit, hit_up, set_p, evt, commit;

    assign hit    = wr_en && (wr_addr == AW'(i));
    assign hit_up = IS_LO ? (wr_en && (wr_addr == AW'(i+1))) : 1'b0;
    assign set_p  = IS_LO ? hit_up : hit;
    assign shd_nx = hit ? wr_data : shd_r;
    assign pnd_nx = pnd_r | set_p;
    assign evt    = MODE_V ? frame_evt : load_evt;
    assign commit = pnd_nx && evt && (!lock_on || IS_LOCK);

    always_ff @(posedge clk) begin
      if (rst) begin
        shd_r <= RV;
        act_r <= RV;
        pnd_r <= 1'b0;
      end else begin
        shd_r <= shd_nx;
        pnd_r <= pnd_nx && !commit;
        if (commit) act_r <= shd_nx;
      end
    end

    assign cfg_q[i*DW +: DW] = act_r;
    assign pend_q[i]         = pnd_r;
  end
endmodule

// File: rtl/cfg3w_port.sv
module cfg3w_port #(
  parameter int                      NUM_REGS     = 32,
  parameter int                      AW           = 8,
  parameter int                      DW           = 6,
  parameter int                      EXTRA_BITS   = 2,
  parameter int                      LOCK_ADDR    = 25,
  parameter logic [NUM_REGS-1:0]     VSYNC_MASK   = 32'h0000_FF10,
  parameter logic [NUM_REGS-1:0]     WIDE_LO_MASK = 32'h0000_0410
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ser_clk,
  input  logic                     ser_dat,
  input  logic                     ser_load,
  input  logic                     vsync_in,
  input  logic                     hsync_in,
  output logic [NUM_REGS*DW-1:0]   cfg_q
);
  localparam int NSIG = 5;
  localparam int NEDG = 4;

  logic [NSIG-1:0] lvl;
  logic [NEDG-1:0] prv;
  logic sck_rise, load_rise, vd_fall, hd_fall, armed, frame_evt;
  logic wr_en;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic [NUM_REGS-1:0] pend_vec;

  cfg3w_sync #(.W(NSIG), .EW(NEDG)) u_sync (
    .clk(clk), .rst(rst),
    .raw({ser_dat, hsync_in, vsync_in, ser_load, ser_clk}),
    .lvl(lvl), .prv(prv)
  );

  assign sck_rise  =  lvl[0] & ~prv[0];
  assign load_rise =  lvl[1] & ~prv[1];
  assign vd_fall   = ~lvl[2] &  prv[2];
  assign hd_fall   = ~lvl[3] &  prv[3];

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= vd_fall | (armed & ~hd_fall);
  end
  assign frame_evt = hd_fall & armed;

  cfg3w_frame_rx #(.AW(AW), .DW(DW), .EXTRA(EXTRA_BITS)) u_rx (
    .clk(clk), .rst(rst),
    .bit_strobe(sck_rise), .bit_val(lvl[4]),
    .load_lvl(lvl[1]), .load_rise(load_rise),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  cfg3w_bank #(
    .N(NUM_REGS), .AW(AW), .DW(DW), .LOCK(LOCK_ADDR),
    .VS(VSYNC_MASK), .WLO(WIDE_LO_MASK)
  ) u_bank (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .load_evt(load_rise), .frame_evt(frame_evt),
    .cfg_q(cfg_q), .pend_q(pend_vec)
  );
endmodule

// File: rtl/cfg3w_chk.sv
module cfg3w_chk
  import cfg3w_pkg::*;
#(
  parameter int                  NUM_REGS     = 32,
  parameter int                  DW           = 6,
  parameter int                  LOCK_ADDR    = 25,
  parameter logic [NUM_REGS-1:0] WIDE_LO_MASK = '0
) (
  input logic                   clk,
  input logic                   rst,
  input logic [NUM_REGS*DW-1:0] cfg_q,
  input logic [NUM_REGS-1:0]    pend_q,
  input logic                   load_rise,
  input logic                   frame_evt
);
  localparam int CW = NUM_REGS * DW;
  localparam logic [CW-1:0] KEEP = ~(CW'({DW{1'b1}}) << (LOCK_ADDR * DW));

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_rst
    localparam logic [DW-1:0] RV = DW'(def_val(i, LOCK_ADDR));
    AST_RESET_DEFAULTS: assert property (@(posedge clk) disable iff (rst) $fell(rst) |-> (cfg_q[i*DW +: DW] == RV)); // R1
  end

  AST_RESET_NO_PENDING: assert property (@(posedge clk) disable iff (rst) $fell(rst) |-> (pend_q == '0)); // R1

  AST_CHANGE_NEEDS_EVENT: assert property (@(posedge clk) disable iff (rst) (cfg_q != $past(cfg_q)) |-> $past(load_rise || frame_evt)); // R5 R6

  AST_LOCK_FREEZES: assert property (@(posedge clk) disable iff (rst) $past(cfg_q[LOCK_ADDR*DW]) |-> ((cfg_q & KEEP) == ($past(cfg_q) & KEEP))); // R9

  for (genvar i = 0; i < NUM_REGS-1; i++) begin : g_pair
    if (WIDE_LO_MASK[i]) begin : g_on
      AST_WIDE_PAIRED: assert property (@(posedge clk) disable iff (rst) pend_q[i] == pend_q[i+1]); // R7
    end
  end
endmodule

bind cfg3w_port cfg3w_chk #(
  .NUM_REGS(NUM_REGS), .DW(DW), .LOCK_ADDR(LOCK_ADDR), .WIDE_LO_MASK(WIDE_LO_MASK)
) u_chk (
  .clk(clk), .rst(rst), .cfg_q(cfg_q), .pend_q(pend_vec),
  .load_rise(load_rise), .frame_evt(frame_evt)
);

// File: tb/tb_cfg3w_port.sv
module tb_cfg3w_port;
  localparam int NR = 32;
  localparam int DW = 6;
  localparam int LK = 25;
  localparam logic [NR-1:0] VS_M = 32'h0000_FF10;
  localparam logic [NR-1:0] WL_M = 32'h0000_0410;

  logic clk = 0, rst = 1;
  logic sck = 0, dat = 0, sl = 1, vd = 1, hd = 1;
  logic [NR*DW-1:0] cfg;
  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cfg3w_port #(.NUM_REGS(NR), .DW(DW), .LOCK_ADDR(LK), .VSYNC_MASK(VS_M), .WIDE_LO_MASK(WL_M)) dut (
    .clk(clk), .rst(rst), .ser_clk(sck), .ser_dat(dat), .ser_load(sl),
    .vsync_in(vd), .hsync_in(hd), .cfg_q(cfg)
  );

  function automatic int bdef(int i);
    return (i == LK) ? 0 : (i * 7 + 3) % 64;
  endfunction

  function automatic bit mvs(int i);
    if (i == LK) return 0;
    if (WL_M[i] && i < NR-1) return VS_M[i+1];
    return VS_M[i];
  endfunction

  // ---------------- behavioural reference model ----------------
  int m_act[NR], m_sh[NR];
  bit m_pd[NR];
  bit m_armed;
  bit bq[$];
  logic [4:0] h1, h2, h3;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NR; i++) begin m_act[i] = bdef(i); m_sh[i] = bdef(i); m_pd[i] = 0; end
      m_armed = 0; bq.delete(); h1 = 0; h2 = 0; h3 = 0;
    end else begin
      bit sck_r, sl_r, vd_f, hd_f, vcom, lk;
      int a, d;
      sck_r = h2[0] & !h3[0];
      sl_r  = h2[1] & !h3[1];
      vd_f  = !h2[2] & h3[2];
      hd_f  = !h2[3] & h3[3];
      vcom  = hd_f && m_armed;
      m_armed = vd_f || (m_armed && !hd_f);
      lk = m_act[LK][0];
      if (sl_r && bq.size() >= 14 && bq.size() <= 16) begin
        a = 0; d = 0;
        for (int k = 0; k < 8; k++) a |= int'(bq[k]) << k;
        for (int k = 0; k < 6; k++) d |= int'(bq[8+k]) << k;
        if (a < NR) begin
          m_sh[a] = d;
          if (WL_M[a] && a < NR-1) ;
          else if (a > 0 && WL_M[a-1]) begin m_pd[a] = 1; m_pd[a-1] = 1; end
          else m_pd[a] = 1;
        end
      end
      for (int i = 0; i < NR; i++) begin
        bit ev;
        ev = mvs(i) ? vcom : sl_r;
        if (m_pd[i] && ev && (!lk || i == LK)) begin m_act[i] = m_sh[i]; m_pd[i] = 0; end
      end
      if (h2[1]) bq.delete();
      else if (sck_r && bq.size() < 17) bq.push_back(h2[4]);
      h3 = h2; h2 = h1; h1 = {dat, hd, vd, sl, sck};
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      tests++;
      for (int i = 0; i < NR; i++) begin
        if (int'(cfg[i*DW +: DW]) != m_act[i]) begin
          fails++;
          $display("FAIL R2/R5/R6 model compare reg %0d got %0d exp %0d", i, cfg[i*DW +: DW], m_act[i]);
          break;
        end
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic chk(int idx, int exp, string tag);
    tests++;
    if (int'(cfg[idx*DW +: DW]) != exp) begin
      fails++;
      $display("FAIL %s reg %0d got %0d exp %0d", tag, idx, cfg[idx*DW +: DW], exp);
    end
  endtask

  task automatic send_bit(bit b);
    @(negedge clk) dat = b;
    repeat (3) @(negedge clk);
    sck = 1;
    repeat (3) @(negedge clk);
    sck = 0;
  endtask

  task automatic frame(int a, int d, int nb, bit raise);
    @(negedge clk) sl = 0;
    repeat (3) @(negedge clk);
    for (int k = 0; k < nb; k++)
      send_bit(k < 8 ? bit'((a >> k) & 1) : (k < 14 ? bit'((d >> (k - 8)) & 1) : 1'b1));
    repeat (3) @(negedge clk);
    if (raise) begin
      sl = 1;
      repeat (8) @(negedge clk);
    end
  endtask

  task automatic pulse_vd();
    @(negedge clk) vd = 0;
    repeat (4) @(negedge clk);
    vd = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_hd();
    @(negedge clk) hd = 0;
    repeat (4) @(negedge clk);
    hd = 1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    repeat (6) @(negedge clk);
    // R1 reset values
    chk(0, bdef(0), "R1");
    chk(LK, 0, "R1");
    chk(31, bdef(31), "R1");
    frame(3, 5, 10, 1);                  // short frame: only a strobe event
    chk(3, bdef(3), "R1 no pending");
    // R2 basic 14-bit write, R5 strobe commit
    frame(3, 6'h2A, 14, 1);
    chk(3, 6'h2A, "R2");
    // R3 16-bit frame accepted
    frame(6, 6'h15, 16, 1);
    chk(6, 6'h15, "R3");
    // R4 12-bit frame discarded
    frame(7, 6'h3F, 12, 1);
    chk(7, bdef(7), "R4");
    // R3 17-bit frame discarded
    frame(7, 6'h3F, 17, 1);
    chk(7, bdef(7), "R3 over-length");
    // R4 serial clocks while strobe high are ignored
    for (int k = 0; k < 5; k++) send_bit(1'b1);
    frame(2, 6'h33, 14, 1);
    chk(2, 6'h33, "R4 clocks while load high");
    // R10 out-of-range address
    frame(40, 6'h11, 14, 1);
    chk(8, bdef(8), "R10");
    // R5 latency of strobe commit
    frame(1, 6'h0C, 14, 0);
    @(negedge clk) sl = 1;
    repeat (2) @(negedge clk);
    chk(1, bdef(1), "R5 before third edge");
    @(negedge clk);
    chk(1, 6'h0C, "R5 at third edge");
    repeat (6) @(negedge clk);
    // R6 frame-synchronous register
    frame(9, 6'h07, 14, 1);
    chk(9, bdef(9), "R6 held after strobe");
    pulse_hd();
    chk(9, bdef(9), "R6 HD alone");
    pulse_vd();
    pulse_hd();
    chk(9, 6'h07, "R6 VD then HD");
    chk(8, bdef(8), "R10 after frame sync");
    // R7 R8 wide pair 4/5 on the strobe
    frame(4, 6'h01, 14, 1);
    chk(4, bdef(4), "R7 lower alone");
    frame(5, 6'h02, 14, 1);
    chk(4, 6'h01, "R8 lower inherits strobe mode");
    chk(5, 6'h02, "R7 upper");
    // R7 wide pair 10/11 frame-synchronous
    frame(10, 6'h21, 14, 1);
    frame(11, 6'h12, 14, 1);
    chk(10, bdef(10), "R7 pair held");
    chk(11, bdef(11), "R7 pair held");
    pulse_vd();
    pulse_hd();
    chk(10, 6'h21, "R7 pair commit");
    chk(11, 6'h12, "R7 pair commit");
    // R11 HD sync latency
    frame(12, 6'h3C, 14, 1);
    pulse_vd();
    @(negedge clk) hd = 0;
    repeat (2) @(negedge clk);
    chk(12, bdef(12), "R11 before third edge");
    @(negedge clk);
    chk(12, 6'h3C, "R11 at third edge");
    repeat (3) @(negedge clk);
    hd = 1;
    repeat (4) @(negedge clk);
    // R9 update lock
    frame(LK, 1, 14, 1);
    chk(LK, 1, "R9 lock set");
    frame(3, 6'h11, 14, 1);
    chk(3, 6'h2A, "R9 blocked");
    frame(LK, 0, 14, 1);
    chk(LK, 0, "R9 lock cleared");
    chk(3, 6'h2A, "R9 still held");
    frame(0, 0, 8, 1);
    chk(3, 6'h11, "R9 released");
    repeat (10) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule